// File: doc/BRIEF.md
# LPC Host Cycle Initiator

This block is the host-side master for a Low Pin Count bus. A requester hands it one command at a time: I/O or memory space, read or write, an address and, for writes, a data byte. The block then owns the bus frame. It pulls the frame strobe low for a single start clock. It sends a cycle-type nibble, the address nibbles and any write data. It turns the bus around and then listens to the peripheral's SYNC nibbles.

The SYNC interpreter accepts ready, unbounded long waits and a bounded run of short waits. It flags the error code. It rejects codes it does not know and gives up when nothing answers. For reads it collects the data byte as two nibbles. After the peripheral's two-clock turn-around it raises a one-clock done pulse. The pulse carries a completion status and the read byte. The bidirectional LAD bus is modelled as a drive value, an output enable and a sampled input.

Top module: `lpc_host_init`

## Requirements
- R1: Out of reset and while idle, lframe_no is high, lad_oe_o is low, done_o is low and req_ready_o is high.
- R2: The clock after a request is accepted, the block drives lframe_no low with lad_o=0x0 and lad_oe_o high, for exactly one clock.
- R3: The next clock carries the cycle-type nibble {1'b0, mem, write, 1'b0}: 0x0 I/O read, 0x2 I/O write, 0x4 memory read, 0x6 memory write.
- R4: The address follows, most significant nibble first: 4 nibbles of addr[15:0] for I/O, 8 nibbles of addr[31:0] for memory.
- R5: A write then sends its data byte as two nibbles, bits [7:4] first.
- R6: The host drives 0xF for one turn-around clock, then releases LAD (lad_oe_o low). It keeps LAD released through SYNC, the read data and the two peripheral turn-around clocks.
- R7: SYNC 0x0 completes the cycle with status 0 (ok). SYNC 0x6 (long wait) may repeat without limit.
- R8: Up to 8 consecutive SYNC 0x5 (short wait) are tolerated. A 9th consecutive one ends the cycle with status 2 (protocol error). Any other code restarts the count.
- R9: SYNC 0xA ends the wait with status 1 (error). On a read, the two data nibbles are still collected and returned.
- R10: Any other SYNC code ends the cycle with status 2 and read data 0xFF. This includes 0xF after a valid SYNC has been seen.
- R11: If the first 3 SYNC clocks all show 0xF, the cycle ends with status 3 (no response) and read data 0xFF. A valid code on the 3rd clock still counts.
- R12: Read data is taken as two nibbles, [7:4] then [3:0], on the two clocks after the accepting SYNC.
- R13: done_o pulses for one clock, on the clock after the second peripheral turn-around clock, with status_o and rdata_o valid. Writes report rdata_o=0xFF.
- R14: req_ready_o is high only while idle. A req_valid_i raised during a cycle is ignored and starts no new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_mem_i | input | 1 | 1 = memory space, 0 = I/O space |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Cycle address (I/O uses [15:0]) |
| req_wdata_i | input | 8 | Write data byte |
| req_ready_o | output | 1 | Block idle, request will be taken |
| lframe_no | output | 1 | Frame strobe, active low |
| lad_o | output | 4 | LAD drive value |
| lad_oe_o | output | 1 | LAD output enable |
| lad_i | input | 4 | LAD sampled value |
| done_o | output | 1 | One-clock completion pulse |
| status_o | output | 2 | 0 ok, 1 error, 2 protocol error, 3 no response |
| rdata_o | output | 8 | Read data byte |

## Verification
The frame strobe falls one clock after the edge that takes the request. Each later phase takes a fixed number of clocks: one type clock, 4 or 8 address clocks, 2 write-data clocks, 2 host turn-around clocks. The bench walks through them one falling edge at a time and checks each nibble in the clock it is due. The bench drives a SYNC code or data nibble on the falling edge of a SYNC clock, and the block samples it on the next rising edge. After the final SYNC or data nibble, the bench counts two peripheral turn-around clocks. It then expects done_o, status_o and rdata_o on exactly the third falling edge, and done_o low on the fourth.

// File: rtl/lpc_host_pkg.sv
`timescale 1ns/1ps
package lpc_host_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_CTYP, ST_ADDR, ST_WDAT, ST_HTAR1, ST_HTAR2,
    ST_SYNC, ST_RDAT, ST_PTAR1, ST_PTAR2
  } phase_e;

  typedef enum logic [1:0] {
    CS_OK = 2'd0, CS_ERR = 2'd1, CS_PROTO = 2'd2, CS_TMO = 2'd3
  } cstat_e;

  localparam logic [3:0] SY_READY = 4'h0;
  localparam logic [3:0] SY_SHORT = 4'h5;
  localparam logic [3:0] SY_LONG  = 4'h6;
  localparam logic [3:0] SY_ERR   = 4'hA;
  localparam logic [3:0] SY_NONE  = 4'hF;

  typedef struct packed {
    logic        mem;
    logic        wr;
    logic [31:0] addr;
    logic [7:0]  wdata;
  } req_t;
endpackage

// File: rtl/lpc_host_tx.sv
`timescale 1ns/1ps
module lpc_host_tx
  import lpc_host_pkg::*;
#(
  parameter int ADDR_NIBS = 8
) (
  input  phase_e      phase_i,
  input  logic [2:0]  nib_idx_i,
  input  req_t        rq_i,
  output logic        lframe_no,
  output logic [3:0]  lad_o,
  output logic        lad_oe_o
);
  logic [31:0] addr_al;
  logic [3:0]  addr_nib [ADDR_NIBS];

  // I/O addresses are left aligned so both spaces shift out from nibble 0
  assign addr_al = rq_i.mem ? rq_i.addr : {rq_i.addr[15:0], 16'h0000};

  for (genvar g = 0; g < ADDR_NIBS; g++) begin : g_nib
    assign addr_nib[g] = addr_al[31-4*g -: 4];
  end

  always_comb begin
    lframe_no = 1'b1;
    lad_o     = 4'h0;
    lad_oe_o  = 1'b0;
    case (phase_i)
      ST_START: begin lframe_no = 1'b0; lad_oe_o = 1'b1; end
      ST_CTYP:  begin lad_o = {1'b0, rq_i.mem, rq_i.wr, 1'b0}; lad_oe_o = 1'b1; end
      ST_ADDR:  begin lad_o = addr_nib[nib_idx_i]; lad_oe_o = 1'b1; end
      ST_WDAT:  begin
        lad_o    = nib_idx_i[0] ? rq_i.wdata[3:0] : rq_i.wdata[7:4];
        lad_oe_o = 1'b1;
      end
      ST_HTAR1: begin lad_o = 4'hF; lad_oe_o = 1'b1; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/lpc_host_sync.sv
`timescale 1ns/1ps
module lpc_host_sync
  import lpc_host_pkg::*;
#(
  parameter int SHORT_MAX   = 8,
  parameter int NORESP_CLKS = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic [3:0] lad_i,
  output logic       hit_ok_o,
  output logic       hit_err_o,
  output logic       hit_proto_o,
  output logic       hit_tmo_o
);
  localparam int SC_W = $clog2(SHORT_MAX + 1);
  localparam int NR_W = $clog2(NORESP_CLKS + 1);

  logic [SC_W-1:0] short_cnt;
  logic [NR_W-1:0] idle_cnt;
  logic            seen;
  logic            short_full;

  assign short_full = (short_cnt == SC_W'(SHORT_MAX));

  always_comb begin
    hit_ok_o    = 1'b0;
    hit_err_o   = 1'b0;
    hit_proto_o = 1'b0;
    hit_tmo_o   = 1'b0;
    if (active_i) begin
      case (lad_i)
        SY_READY: hit_ok_o    = 1'b1;
        SY_ERR:   hit_err_o   = 1'b1;
        SY_SHORT: hit_proto_o = short_full;
        SY_LONG:  ;
        SY_NONE:  begin
          // a float after a real SYNC is a broken handshake, not silence
          if (seen) hit_proto_o = 1'b1;
          else      hit_tmo_o   = (idle_cnt == NR_W'(NORESP_CLKS - 1));
        end
        default:  hit_proto_o = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      short_cnt <= '0;
      idle_cnt  <= '0;
      seen      <= 1'b0;
    end else if (!active_i) begin
      short_cnt <= '0;
      idle_cnt  <= '0;
      seen      <= 1'b0;
    end else begin
      seen      <= seen | (lad_i != SY_NONE);
      short_cnt <= (lad_i != SY_SHORT) ? '0 : (short_full ? short_cnt : short_cnt + 1'b1);
      if (lad_i == SY_NONE && idle_cnt != NR_W'(NORESP_CLKS)) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  AST_SYNC_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hit_ok_o, hit_err_o, hit_proto_o, hit_tmo_o})); // R10
  AST_SHORT_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && $past(active_i) && lad_i == SY_SHORT && !hit_proto_o |-> short_cnt != SC_W'(SHORT_MAX)); // R8
endmodule

// File: rtl/lpc_host_init.sv
`timescale 1ns/1ps
module lpc_host_init
  import lpc_host_pkg::*;
#(
  parameter int SHORT_MAX   = 8,
  parameter int NORESP_CLKS = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        req_mem_i,
  input  logic        req_write_i,
  input  logic [31:0] req_addr_i,
  input  logic [7:0]  req_wdata_i,
  output logic        req_ready_o,
  output logic        lframe_no,
  output logic [3:0]  lad_o,
  output logic        lad_oe_o,
  input  logic [3:0]  lad_i,
  output logic        done_o,
  output logic [1:0]  status_o,
  output logic [7:0]  rdata_o
);
  phase_e     phase;
  req_t       rq;
  logic [2:0] nib_cnt;
  logic [2:0] addr_last;
  cstat_e     status_q;
  logic [7:0] rdata_q;
  logic       done_q;
  logic       hit_ok, hit_err, hit_proto, hit_tmo;

  assign addr_last   = rq.mem ? 3'd7 : 3'd3;
  assign req_ready_o = (phase == ST_IDLE);
  assign done_o      = done_q;
  assign status_o    = status_q;
  assign rdata_o     = rdata_q;

  lpc_host_tx #(.ADDR_NIBS(8)) u_tx (
    .phase_i   (phase),
    .nib_idx_i (nib_cnt),
    .rq_i      (rq),
    .lframe_no (lframe_no),
    .lad_o     (lad_o),
    .lad_oe_o  (lad_oe_o)
  );

  lpc_host_sync #(.SHORT_MAX(SHORT_MAX), .NORESP_CLKS(NORESP_CLKS)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (phase == ST_SYNC),
    .lad_i       (lad_i),
    .hit_ok_o    (hit_ok),
    .hit_err_o   (hit_err),
    .hit_proto_o (hit_proto),
    .hit_tmo_o   (hit_tmo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase    <= ST_IDLE;
      rq       <= '0;
      nib_cnt  <= '0;
      status_q <= CS_OK;
      rdata_q  <= 8'hFF;
      done_q   <= 1'b0;
    end else begin
      done_q <= (phase == ST_PTAR2);
      case (phase)
        ST_IDLE: if (req_valid_i) begin
          rq.mem   <= req_mem_i;
          rq.wr    <= req_write_i;
          rq.addr  <= req_addr_i;
          rq.wdata <= req_wdata_i;
          status_q <= CS_OK;
          rdata_q  <= 8'hFF;
          phase    <= ST_START;
        end
        ST_START: phase <= ST_CTYP;
        ST_CTYP:  begin nib_cnt <= '0; phase <= ST_ADDR; end
        ST_ADDR:  begin
          if (nib_cnt == addr_last) begin
            nib_cnt <= '0;
            phase   <= rq.wr ? ST_WDAT : ST_HTAR1;
          end else nib_cnt <= nib_cnt + 1'b1;
        end
        ST_WDAT:  begin
          if (nib_cnt[0]) begin nib_cnt <= '0; phase <= ST_HTAR1; end
          else nib_cnt <= nib_cnt + 1'b1;
        end
        ST_HTAR1: phase <= ST_HTAR2;
        ST_HTAR2: phase <= ST_SYNC;
        ST_SYNC:  begin
          if (hit_ok || hit_err) begin
            status_q <= hit_err ? CS_ERR : CS_OK;
            nib_cnt  <= '0;
            phase    <= rq.wr ? ST_PTAR1 : ST_RDAT;
          end else if (hit_proto) begin
            status_q <= CS_PROTO;
            phase    <= ST_PTAR1;
          end else if (hit_tmo) begin
            status_q <= CS_TMO;
            phase    <= ST_PTAR1;
          end
        end
        ST_RDAT:  begin
          if (nib_cnt[0]) begin
            rdata_q[3:0] <= lad_i;
            nib_cnt      <= '0;
            phase        <= ST_PTAR1;
          end else begin
            rdata_q[7:4] <= lad_i;
            nib_cnt      <= 3'd1;
          end
        end
        ST_PTAR1: phase <= ST_PTAR2;
        ST_PTAR2: phase <= ST_IDLE;
        default:  phase <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> lframe_no && !lad_oe_o && !done_o || done_o && lframe_no && !lad_oe_o); // R1
  AST_START_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lframe_no |=> lframe_no); // R2
  AST_START_LAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lframe_no |-> lad_oe_o && lad_o == 4'h0); // R2
  AST_SYNC_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase == ST_SYNC || phase == ST_RDAT || phase == ST_PTAR1 || phase == ST_PTAR2 |-> !lad_oe_o); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R13
  AST_TMO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && status_o == 2'd3 |-> rdata_o == 8'hFF); // R11
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o && req_valid_i && phase != ST_PTAR2 |=> !req_ready_o); // R14
endmodule

// File: tb/lpc_host_init_tb.sv
`timescale 1ns/1ps
module lpc_host_init_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0, req_mem = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, lframe_n, lad_oe, done;
  logic [3:0]  lad_out, lad_in = 4'hF;
  logic [1:0]  status;
  logic [7:0]  rdata;

  int n_chk = 0, n_err = 0;
  logic [3:0] sy [20];
  int sy_n = 0;

  always #2.5 clk = ~clk;

  lpc_host_init u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_mem_i(req_mem),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_ready_o(req_ready), .lframe_no(lframe_n), .lad_o(lad_out), .lad_oe_o(lad_oe),
    .lad_i(lad_in), .done_o(done), .status_o(status), .rdata_o(rdata)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  // one full bus cycle; sy[0:sy_n-1] are the SYNC nibbles the peripheral returns
  task automatic do_cycle(input string tg, input bit mem, input bit wr, input logic [31:0] addr,
                          input logic [7:0] wd, input logic [7:0] rd, input bit takes_data,
                          input int exp_st, input logic [7:0] exp_rd, input bit poke);
    int na = mem ? 8 : 4;
    @(negedge clk);
    chk("R14", {tg, " ready before"}, req_ready, 1);
    req_valid = 1'b1; req_mem = mem; req_write = wr; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2", {tg, " start frame"}, lframe_n, 0);
    chk("R2", {tg, " start lad"}, {lad_oe, lad_out}, 5'h10);
    chk("R14", {tg, " busy ready"}, req_ready, 0);
    @(negedge clk);
    chk("R2", {tg, " frame one clock"}, lframe_n, 1);
    chk("R3", {tg, " cycle type"}, {lad_oe, lad_out}, {1'b1, 1'b0, mem, wr, 1'b0});
    if (poke) begin
      req_valid = 1'b1; req_mem = ~mem; req_write = ~wr; req_addr = ~addr;
    end
    for (int i = 0; i < na; i++) begin
      @(negedge clk);
      if (poke) req_valid = 1'b0;
      chk("R4", {tg, " addr nibble"}, {lad_oe, lad_out}, {1'b1, 4'((addr >> (4*(na-1-i))) & 32'hF)});
    end
    if (wr) begin
      @(negedge clk);
      chk("R5", {tg, " wdata hi"}, {lad_oe, lad_out}, {1'b1, wd[7:4]});
      @(negedge clk);
      chk("R5", {tg, " wdata lo"}, {lad_oe, lad_out}, {1'b1, wd[3:0]});
    end
    @(negedge clk);
    chk("R6", {tg, " host tar drive"}, {lad_oe, lad_out}, 5'h1F);
    @(negedge clk);
    chk("R6", {tg, " host tar release"}, lad_oe, 0);
    for (int k = 0; k < sy_n; k++) begin
      @(negedge clk);
      chk("R6", {tg, " released in sync"}, lad_oe, 0);
      lad_in = sy[k];
    end
    if (takes_data) begin
      @(negedge clk); lad_in = rd[7:4];
      @(negedge clk); lad_in = rd[3:0];
    end
    @(negedge clk);
    lad_in = 4'hF;
    chk("R6", {tg, " released ptar1"}, lad_oe, 0);
    chk("R13", {tg, " no early done"}, done, 0);
    @(negedge clk);
    chk("R13", {tg, " no done ptar2"}, done, 0);
    @(negedge clk);
    chk("R13", {tg, " done pulse"}, done, 1);
    chk("R13", {tg, " status"}, status, exp_st);
    chk("R12", {tg, " rdata"}, rdata, exp_rd);
    @(negedge clk);
    chk("R13", {tg, " done single"}, done, 0);
    chk("R1", {tg, " idle again"}, {req_ready, lframe_n, lad_oe}, 3'b110);
    if (poke) begin
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        chk("R14", {tg, " no ghost frame"}, lframe_n, 1);
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "reset outputs", {lframe_n, lad_oe, done, req_ready}, 4'b1001);
  endtask

  task automatic t_io_read_ok();  // R7 R12
    sy_n = 1; sy[0] = 4'h0;
    do_cycle("io_rd", 1'b0, 1'b0, 32'hDEAD_1234, 8'h00, 8'hA5, 1'b1, 0, 8'hA5, 1'b0);
  endtask

  task automatic t_io_write_long();  // R7 R5
    sy_n = 4; sy[0] = 4'h6; sy[1] = 4'h6; sy[2] = 4'h6; sy[3] = 4'h0;
    do_cycle("io_wr_long", 1'b0, 1'b1, 32'h0000_80C3, 8'h5E, 8'h00, 1'b0, 0, 8'hFF, 1'b0);
  endtask

  task automatic t_mem_read_short8();  // R8 boundary
    sy_n = 9;
    for (int i = 0; i < 8; i++) sy[i] = 4'h5;
    sy[8] = 4'h0;
    do_cycle("mem_rd_short8", 1'b1, 1'b0, 32'h89AB_CDEF, 8'h00, 8'h3C, 1'b1, 0, 8'h3C, 1'b0);
  endtask

  task automatic t_mem_write_short9();  // R8 overflow
    sy_n = 9;
    for (int i = 0; i < 9; i++) sy[i] = 4'h5;
    do_cycle("mem_wr_short9", 1'b1, 1'b1, 32'h1357_9BDF, 8'hC7, 8'h00, 1'b0, 2, 8'hFF, 1'b0);
  endtask

  task automatic t_short_restart();  // R8 run resets on other code
    sy_n = 18;
    for (int i = 0; i < 8; i++) sy[i] = 4'h5;
    sy[8] = 4'h6;
    for (int i = 9; i < 17; i++) sy[i] = 4'h5;
    sy[17] = 4'h0;
    do_cycle("short_restart", 1'b0, 1'b0, 32'h0000_4242, 8'h00, 8'h81, 1'b1, 0, 8'h81, 1'b0);
  endtask

  task automatic t_err_read();  // R9
    sy_n = 2; sy[0] = 4'h6; sy[1] = 4'hA;
    do_cycle("err_rd", 1'b0, 1'b0, 32'h0000_0060, 8'h00, 8'h96, 1'b1, 1, 8'h96, 1'b0);
  endtask

  task automatic t_unknown();  // R10
    sy_n = 1; sy[0] = 4'h3;
    do_cycle("unknown", 1'b0, 1'b0, 32'h0000_0070, 8'h00, 8'h00, 1'b0, 2, 8'hFF, 1'b0);
    sy_n = 2; sy[0] = 4'h6; sy[1] = 4'hF;
    do_cycle("float_after", 1'b1, 1'b0, 32'hFEDC_BA98, 8'h00, 8'h00, 1'b0, 2, 8'hFF, 1'b0);
  endtask

  task automatic t_noresp();  // R11
    sy_n = 3; sy[0] = 4'hF; sy[1] = 4'hF; sy[2] = 4'hF;
    do_cycle("noresp", 1'b0, 1'b0, 32'h0000_0378, 8'h00, 8'h00, 1'b0, 3, 8'hFF, 1'b0);
    sy_n = 3; sy[0] = 4'hF; sy[1] = 4'hF; sy[2] = 4'h0;
    do_cycle("late_ok", 1'b0, 1'b0, 32'h0000_0379, 8'h00, 8'h5A, 1'b1, 0, 8'h5A, 1'b0);
  endtask

  task automatic t_busy_ignore();  // R14
    sy_n = 1; sy[0] = 4'h0;
    do_cycle("busy_poke", 1'b0, 1'b1, 32'h0000_2E2F, 8'h11, 8'h00, 1'b0, 0, 8'hFF, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_io_read_ok();
    t_io_write_long();
    t_mem_read_short8();
    t_mem_write_short9();
    t_short_restart();
    t_err_read();
    t_unknown();
    t_noresp();
    t_busy_ignore();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule